// File: doc/BRIEF.md
# Fused Multiply-Add Special-Case Resolver

This block sits in front of a single-precision fused multiply-add unit that computes ±(±(a·b) + ±c). It classifies the three operands and applies three independent sign controls: one on the addend, one on the product and one on the final result. It then settles every outcome that needs no significand arithmetic. These outcomes are NaN inputs, the invalid infinity-times-zero product, infinity arithmetic and zero products. For each one it produces the final word and the invalid and output-denormal flags.

When the operands are all finite and the product is non-zero, the block leaves `handled` low. It forwards the effective product sign, the effective addend sign and the result-flip bit to the main multiply/align/round datapath.

The block can optionally flush subnormal inputs to zero before classification. It captures results in one register stage when `in_valid` is high.

Top module: `fma_sc_resolve`

## Requirements
- R1: Each accepted input (`in_valid` high at a rising edge) appears on the outputs one cycle later with `out_valid` high. With `in_valid` low, `out_valid` is low on the next cycle and the data outputs hold their value. Reset clears `out_valid`, `handled` and all data outputs.
- R2: With `in_flush` high, any subnormal operand (exponent field zero, fraction non-zero) is replaced by a zero of the same sign before any other decision is made.
- R3: If any operand is a NaN, the result is a NaN chosen by the selector. `flag_invalid` is raised if any operand is a signaling NaN (top fraction bit, bit 22, clear). With the default selector, the chosen operand is the first match in this order: signaling c, signaling a, signaling b, quiet c, quiet a, then b. The chosen NaN is returned with bit 22 forced to one.
- R4: With the default selector, when the product is inf·0 or 0·inf and c is a quiet NaN, the result is the default NaN 0x7FC00000 and `flag_invalid` is raised.
- R5: No sign control changes a propagated NaN. With `dnan_mode` high, every NaN outcome returns 0x7FC00000 while keeping the invalid flag the selector produced.
- R6: With no NaN present, an inf·0 or 0·inf product gives 0x7FC00000 and raises `flag_invalid`.
- R7: When c is infinite and the product is infinite with the opposite effective sign, the result is 0x7FC00000 with `flag_invalid`. Any other infinite c gives an infinity carrying the effective c sign, flipped by `neg_result`.
- R8: When c is finite and the product is infinite, the result is an infinity carrying the effective product sign, flipped by `neg_result`.
- R9: For a zero product and a zero c, the result is a zero. If the two effective signs agree, it takes that sign. If they differ, it is negative only when `rnd_mode` is 2'b10 (toward minus infinity). `neg_result` then flips the sign.
- R10: For a zero product and a subnormal c with `out_flush` high, the result is a zero carrying the effective c sign flipped by `neg_result`, and `flag_out_denorm` is raised.
- R11: For a zero product and any other non-zero c, the result is c with only its sign bit flipped by `neg_result`; `neg_addend` has no effect on it.
- R12: When all operands are finite and the product is non-zero, `handled` is low, `result` and both flags are zero, and `nrm_prod_sign`, `nrm_add_sign` and `nrm_flip` carry a⊕b⊕`neg_product`, c⊕`neg_addend` and `neg_result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| op_c | input | 32 | Addend |
| neg_addend | input | 1 | Invert the addend sign |
| neg_product | input | 1 | Invert the product sign |
| neg_result | input | 1 | Invert the final sign (not applied to NaNs) |
| in_flush | input | 1 | Flush subnormal inputs to zero |
| out_flush | input | 1 | Flush a subnormal returned addend to zero |
| dnan_mode | input | 1 | Return the default NaN for all NaN outcomes |
| rnd_mode | input | 2 | Rounding mode; 2'b10 is toward minus infinity |
| out_valid | output | 1 | Registered outputs are valid |
| handled | output | 1 | Result settled here; low hands off to the datapath |
| result | output | 32 | Resolved result word |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_out_denorm | output | 1 | Output-denormal flag |
| nrm_prod_sign | output | 1 | Effective product sign for the datapath |
| nrm_add_sign | output | 1 | Effective addend sign for the datapath |
| nrm_flip | output | 1 | Result flip bit for the datapath |

## Verification
The bench builds the block with its defaults: 8 exponent bits, 23 fraction bits and the default NaN selector (policy 0). These values make every bit pattern of single precision reachable, so exact signaling and quiet NaN payloads, subnormals and signed zeros can be driven as literal words. Policy 0 is the selector whose ordering and inf·0-with-quiet-c rule the requirements state. Every outcome can therefore be predicted by hand from the requirement text.

// File: rtl/fma_sc_pkg.sv
package fma_sc_pkg;

  // Operand classification after optional input flushing
  typedef struct packed {
    logic sign;
    logic is_zero;
    logic is_sub;
    logic is_inf;
    logic is_qnan;
    logic is_snan;
  } opclass_t;

  // Selector outcome
  typedef enum logic [1:0] {
    PICK_A   = 2'd0,
    PICK_B   = 2'd1,
    PICK_C   = 2'd2,
    PICK_DEF = 2'd3
  } nan_pick_t;

  localparam logic [1:0] RM_TO_NEG_INF = 2'b10;

endpackage

// File: rtl/fma_sc_classify.sv
module fma_sc_classify
  import fma_sc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_in,
  input  logic         flush_in,
  output logic [W-1:0] op_out,
  output opclass_t     cls
);

  logic [EXP_W-1:0]  raw_exp;
  logic [FRAC_W-1:0] raw_frac;
  logic              raw_sub;
  logic [EXP_W-1:0]  f_exp;
  logic [FRAC_W-1:0] f_frac;
  logic              exp_ones;
  logic              exp_zero;
  logic              frac_zero;

  assign raw_exp  = op_in[W-2:FRAC_W];
  assign raw_frac = op_in[FRAC_W-1:0];
  assign raw_sub  = (raw_exp == '0) && (raw_frac != '0);

  always_comb begin
    if (flush_in && raw_sub) op_out = {op_in[W-1], {(W-1){1'b0}}};
    else                     op_out = op_in;
  end

  assign f_exp     = op_out[W-2:FRAC_W];
  assign f_frac    = op_out[FRAC_W-1:0];
  assign exp_ones  = &f_exp;
  assign exp_zero  = (f_exp == '0);
  assign frac_zero = (f_frac == '0);

  always_comb begin
    cls.sign    = op_out[W-1];
    cls.is_zero = exp_zero && frac_zero;
    cls.is_sub  = exp_zero && !frac_zero;
    cls.is_inf  = exp_ones && frac_zero;
    cls.is_qnan = exp_ones && f_frac[FRAC_W-1];
    cls.is_snan = exp_ones && !frac_zero && !f_frac[FRAC_W-1];
  end

endmodule

// File: rtl/fma_sc_nan_pick.sv
module fma_sc_nan_pick
  import fma_sc_pkg::*;
#(
  parameter int POLICY = 0
) (
  input  opclass_t  ca,
  input  opclass_t  cb,
  input  opclass_t  cc,
  input  logic      infzero,
  output nan_pick_t pick,
  output logic      inv_extra
);

  generate
    if (POLICY == 0) begin : g_sig_first
      // Signaling before quiet, addend first within each class
      always_comb begin
        inv_extra = 1'b0;
        if (infzero && cc.is_qnan) begin
          pick      = PICK_DEF;
          inv_extra = 1'b1;
        end
        else if (cc.is_snan) pick = PICK_C;
        else if (ca.is_snan) pick = PICK_A;
        else if (cb.is_snan) pick = PICK_B;
        else if (cc.is_qnan) pick = PICK_C;
        else if (ca.is_qnan) pick = PICK_A;
        else                 pick = PICK_B;
      end
    end
    else if (POLICY == 1) begin : g_a_c_b
      // inf*0 keeps the addend NaN; otherwise a, then c, then b
      always_comb begin
        inv_extra = infzero;
        if (infzero)                          pick = PICK_C;
        else if (ca.is_snan || ca.is_qnan)    pick = PICK_A;
        else if (cc.is_snan || cc.is_qnan)    pick = PICK_C;
        else                                  pick = PICK_B;
      end
    end
    else begin : g_a_b_c
      always_comb begin
        inv_extra = 1'b0;
        if (ca.is_snan || ca.is_qnan)      pick = PICK_A;
        else if (cb.is_snan || cb.is_qnan) pick = PICK_B;
        else                               pick = PICK_C;
      end
    end
  endgenerate

endmodule

// File: rtl/fma_sc_resolve.sv
module fma_sc_resolve
  import fma_sc_pkg::*;
#(
  parameter int EXP_W      = 8,
  parameter int FRAC_W     = 23,
  parameter int NAN_POLICY = 0,
  localparam int W         = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic         neg_addend,
  input  logic         neg_product,
  input  logic         neg_result,
  input  logic         in_flush,
  input  logic         out_flush,
  input  logic         dnan_mode,
  input  logic [1:0]   rnd_mode,
  output logic         out_valid,
  output logic         handled,
  output logic [W-1:0] result,
  output logic         flag_invalid,
  output logic         flag_out_denorm,
  output logic         nrm_prod_sign,
  output logic         nrm_add_sign,
  output logic         nrm_flip
);

  localparam int QBIT = FRAC_W - 1;
  localparam logic [W-1:0] DEF_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0] QUIET_MASK = W'(1) << QBIT;

  logic [W-1:0] fa, fb, fc;
  opclass_t     ca, cb, cc;

  fma_sc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
    .op_in(op_a), .flush_in(in_flush), .op_out(fa), .cls(ca));
  fma_sc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
    .op_in(op_b), .flush_in(in_flush), .op_out(fb), .cls(cb));
  fma_sc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_c (
    .op_in(op_c), .flush_in(in_flush), .op_out(fc), .cls(cc));

  logic      any_nan, any_snan, infzero, p_inf, p_zero;
  logic      p_sign, c_sign;
  nan_pick_t pick;
  logic      pick_inv;

  assign any_nan  = ca.is_qnan | ca.is_snan | cb.is_qnan | cb.is_snan |
                    cc.is_qnan | cc.is_snan;
  assign any_snan = ca.is_snan | cb.is_snan | cc.is_snan;
  assign infzero  = (ca.is_inf & cb.is_zero) | (ca.is_zero & cb.is_inf);
  assign p_inf    = ca.is_inf | cb.is_inf;
  assign p_zero   = ca.is_zero | cb.is_zero;
  assign p_sign   = ca.sign ^ cb.sign ^ neg_product;
  assign c_sign   = cc.sign ^ neg_addend;

  fma_sc_nan_pick #(.POLICY(NAN_POLICY)) u_pick (
    .ca(ca), .cb(cb), .cc(cc), .infzero(infzero),
    .pick(pick), .inv_extra(pick_inv));

  // Next-state values
  logic         hd_d, inv_d, den_d, zs;
  logic [W-1:0] res_d;

  always_comb begin
    hd_d  = 1'b1;
    inv_d = 1'b0;
    den_d = 1'b0;
    res_d = '0;
    zs    = 1'b0;
    if (any_nan) begin
      inv_d = any_snan | pick_inv;
      unique case (pick)
        PICK_A:  res_d = fa | QUIET_MASK;
        PICK_B:  res_d = fb | QUIET_MASK;
        PICK_C:  res_d = fc | QUIET_MASK;
        default: res_d = DEF_NAN;
      endcase
      if (dnan_mode) res_d = DEF_NAN;
    end
    else if (infzero) begin
      inv_d = 1'b1;
      res_d = DEF_NAN;
    end
    else if (cc.is_inf) begin
      if (p_inf && (p_sign != c_sign)) begin
        inv_d = 1'b1;
        res_d = DEF_NAN;
      end
      else res_d = {c_sign ^ neg_result, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end
    else if (p_inf) begin
      res_d = {p_sign ^ neg_result, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end
    else if (p_zero) begin
      if (cc.is_zero) begin
        if (p_sign == c_sign) zs = p_sign;
        else                  zs = (rnd_mode == RM_TO_NEG_INF);
        res_d = {zs ^ neg_result, {(W-1){1'b0}}};
      end
      else if (cc.is_sub && out_flush) begin
        den_d = 1'b1;
        res_d = {c_sign ^ neg_result, {(W-1){1'b0}}};
      end
      else begin
        res_d = {fc[W-1] ^ neg_result, fc[W-2:0]};
      end
    end
    else begin
      hd_d = 1'b0;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      handled         <= 1'b0;
      result          <= '0;
      flag_invalid    <= 1'b0;
      flag_out_denorm <= 1'b0;
      nrm_prod_sign   <= 1'b0;
      nrm_add_sign    <= 1'b0;
      nrm_flip        <= 1'b0;
    end
    else begin
      out_valid <= in_valid;
      if (in_valid) begin
        handled         <= hd_d;
        result          <= res_d;
        flag_invalid    <= inv_d;
        flag_out_denorm <= den_d;
        nrm_prod_sign   <= p_sign;
        nrm_add_sign    <= c_sign;
        nrm_flip        <= neg_result;
      end
    end
  end

  // Assertions
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && !out_valid)); // R1
  AST_NAN_IN_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_flush &&
     ((&op_a[W-2:FRAC_W] && op_a[FRAC_W-1:0] != '0) ||
      (&op_c[W-2:FRAC_W] && op_c[FRAC_W-1:0] != '0)))
    |=> (handled && (&result[W-2:FRAC_W]) && result[QBIT])); // R3
  AST_INVALID_IS_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_invalid) |-> (handled && (&result[W-2:FRAC_W]) &&
                                     result[QBIT])); // R6
  AST_DENORM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_out_denorm) |-> (handled && result[W-2:0] == '0)); // R10
  AST_HANDOFF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !handled) |-> (result == '0 && !flag_invalid &&
                                 !flag_out_denorm)); // R12

endmodule

// File: tb/fma_sc_resolve_tb_top.sv
module fma_sc_resolve_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a, op_b, op_c;
  logic        neg_addend, neg_product, neg_result;
  logic        in_flush, out_flush, dnan_mode;
  logic [1:0]  rnd_mode;
  logic        out_valid, handled, flag_invalid, flag_out_denorm;
  logic [31:0] result;
  logic        nrm_prod_sign, nrm_add_sign, nrm_flip;

  always #5 clk = ~clk;

  fma_sc_resolve dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .neg_addend(neg_addend), .neg_product(neg_product), .neg_result(neg_result),
    .in_flush(in_flush), .out_flush(out_flush), .dnan_mode(dnan_mode),
    .rnd_mode(rnd_mode), .out_valid(out_valid), .handled(handled),
    .result(result), .flag_invalid(flag_invalid),
    .flag_out_denorm(flag_out_denorm), .nrm_prod_sign(nrm_prod_sign),
    .nrm_add_sign(nrm_add_sign), .nrm_flip(nrm_flip));

  typedef struct {
    logic        hd;
    logic [31:0] res;
    logic        inv;
    logic        den;
    logic [2:0]  sgn;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  localparam logic [31:0] DNAN = 32'h7FC00000;
  localparam logic [31:0] PINF = 32'h7F800000;
  localparam logic [31:0] NINF = 32'hFF800000;
  localparam logic [31:0] ONE  = 32'h3F800000;
  localparam logic [31:0] MONE = 32'hBF800000;
  localparam logic [31:0] TWO  = 32'h40000000;
  localparam logic [31:0] PZ   = 32'h00000000;
  localparam logic [31:0] NZ   = 32'h80000000;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Driver: ctl = {na,np,nr,ifl,ofl,dn,rm[1:0]}
  task automatic send(input logic [31:0] a, b, c, input logic [7:0] ctl,
                      input logic hd, input logic [31:0] res,
                      input logic inv, den, input logic [2:0] sgn,
                      input string tag);
    exp_t e;
    op_a = a; op_b = b; op_c = c;
    {neg_addend, neg_product, neg_result, in_flush, out_flush, dnan_mode,
     rnd_mode} = ctl;
    in_valid = 1'b1;
    e.hd = hd; e.res = res; e.inv = inv; e.den = den; e.sgn = sgn; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected output", {63'd0, out_valid}, 64'd0);
      end
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(handled == e.hd, {e.tag, " handled"}, {63'd0, handled}, {63'd0, e.hd});
        if (e.hd) begin
          check(result == e.res, {e.tag, " result"}, {32'd0, result}, {32'd0, e.res});
        end
        else begin
          check({nrm_prod_sign, nrm_add_sign, nrm_flip} == e.sgn, {e.tag, " signs"},
                {61'd0, nrm_prod_sign, nrm_add_sign, nrm_flip}, {61'd0, e.sgn});
          check(result == 32'd0, {e.tag, " result"}, {32'd0, result}, 64'd0);
        end
        check({flag_invalid, flag_out_denorm} == {e.inv, e.den}, {e.tag, " flags"},
              {62'd0, flag_invalid, flag_out_denorm}, {62'd0, e.inv, e.den});
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    op_a = '0; op_b = '0; op_c = '0;
    {neg_addend, neg_product, neg_result, in_flush, out_flush, dnan_mode,
     rnd_mode} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0 && handled == 1'b0 && result == 32'd0,
          "R1 reset state", {31'd0, out_valid, result}, 64'd0);

    // R3 ordering and quieting
    send(32'h7FC00001, ONE, 32'h7F800005, 8'h00, 1, 32'h7FC00005, 1, 0, 0, "R3 snan c first");
    send(32'h7F800002, 32'hFFC00003, ONE, 8'h00, 1, 32'h7FC00002, 1, 0, 0, "R3 snan a over qnan b");
    send(32'h7FC00007, 32'hFFC00009, ONE, 8'h00, 1, 32'h7FC00007, 0, 0, 0, "R3 qnan a over qnan b");
    send(32'h7FC00007, 32'hFFC00009, 32'h7FC0000B, 8'h00, 1, 32'h7FC0000B, 0, 0, 0, "R3 qnan c over qnan a");
    // R5 NaN sign untouched by controls, default-NaN mode
    send(ONE, 32'hFFC00009, ONE, 8'hE0, 1, 32'hFFC00009, 0, 0, 0, "R5 nan sign kept");
    send(32'h7FC00007, ONE, ONE, 8'h04, 1, DNAN, 0, 0, 0, "R5 dnan mode");
    send(32'h7F800001, ONE, ONE, 8'h04, 1, DNAN, 1, 0, 0, "R5 dnan mode keeps invalid");
    // R4 inf*0 with quiet c
    send(PINF, PZ, 32'h7FC00011, 8'h00, 1, DNAN, 1, 0, 0, "R4 infzero qnan c");
    // R6 inf*0 without NaN
    send(PZ, NINF, ONE, 8'h00, 1, DNAN, 1, 0, 0, "R6 zero times inf");
    // R7 infinite addend
    send(PINF, MONE, PINF, 8'h00, 1, DNAN, 1, 0, 0, "R7 opposite infinities");
    send(PINF, ONE, PINF, 8'h80, 1, DNAN, 1, 0, 0, "R7 negated addend opposite");
    send(TWO, ONE, PINF, 8'h20, 1, NINF, 0, 0, 0, "R7 finite product flipped");
    send(PINF, ONE, PINF, 8'h00, 1, PINF, 0, 0, 0, "R7 like infinities");
    // R8 infinite product
    send(NINF, TWO, ONE, 8'h40, 1, PINF, 0, 0, 0, "R8 negated product inf");
    send(NINF, TWO, ONE, 8'h60, 1, NINF, 0, 0, 0, "R8 product inf flipped");
    // R9 exact zero sums
    send(PZ, ONE, NZ, 8'h00, 1, PZ, 0, 0, 0, "R9 mixed zeros nearest");
    send(PZ, ONE, NZ, 8'h02, 1, NZ, 0, 0, 0, "R9 mixed zeros toward minus");
    send(NZ, ONE, NZ, 8'h00, 1, NZ, 0, 0, 0, "R9 like negative zeros");
    send(NZ, ONE, NZ, 8'h20, 1, PZ, 0, 0, 0, "R9 like zeros flipped");
    // R10 output flush of subnormal addend
    send(PZ, ONE, 32'h80000001, 8'h08, 1, NZ, 0, 1, 0, "R10 neg subnormal flushed");
    send(PZ, ONE, 32'h00000001, 8'h88, 1, NZ, 0, 1, 0, "R10 negated addend sign");
    // R11 zero product returns c
    send(PZ, TWO, ONE, 8'h20, 1, MONE, 0, 0, 0, "R11 c flipped by result");
    send(PZ, TWO, ONE, 8'h80, 1, ONE, 0, 0, 0, "R11 addend negate no effect");
    send(PZ, TWO, 32'h00000003, 8'h00, 1, 32'h00000003, 0, 0, 0, "R11 subnormal c kept");
    // R2 input flushing
    send(32'h00000005, TWO, ONE, 8'h10, 1, ONE, 0, 0, 0, "R2 flushed a gives zero product");
    send(ONE, TWO, 32'h80000004, 8'h10, 0, 32'd0, 0, 0, 3'b010, "R2 flushed c to normal path");
    // R12 normal hand-off
    send(32'h00000005, TWO, ONE, 8'h00, 0, 32'd0, 0, 0, 3'b000, "R12 subnormal a unflushed");
    send(TWO, MONE, ONE, 8'h80, 0, 32'd0, 0, 0, 3'b110, "R12 signs with addend negate");
    send(TWO, MONE, ONE, 8'h60, 0, 32'd0, 0, 0, 3'b001, "R12 product negate and flip");

    in_valid = 1'b0;
    op_a = PINF;
    @(negedge clk);
    @(negedge clk);
    // R1 idle: no valid and held data (last result word was zero from R12)
    check(out_valid == 1'b0 && result == 32'd0, "R1 idle hold",
          {31'd0, out_valid, result}, 64'd0);
    check(exp_q.size() == 0, "R1 all results returned",
          64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule